// File: doc/BRIEF.md
# Deferred nonvolatile register commit sequencer

This block sits behind the serial command decoder of a multi-channel digital potentiometer. The decoder pulses a request strobe when a command that writes nonvolatile storage has been received in full. That can be a direct data-register write for one channel, or a wiper-to-register copy for one channel or for all channels at once. The sequencer holds that request as pending. It does not act on it until the host releases chip select.

On the chip-select release edge, a pending request starts a timed store, provided the write-protect input is high. The cell programming itself is modelled as a fixed delay counted in system clock cycles. While that delay runs, a busy flag is raised; the status path reads it as the write-in-progress bit. When the delay ends, the block drives the storage write enables, the register index and the per-channel data for one cycle, together with a done pulse. Requests that arrive while a store is running are dropped. Requests that arrive while the device is not selected are also dropped.

Top module: `nvc_commit_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and every bit of `nv_we_o` are 0.
- R2: A store starts only on a chip-select release (`cs_ni` low then high) when a request is pending. `busy_o` is 1 in the first cycle after the first clock edge that samples `cs_ni` high. A request strobe by itself starts nothing.
- R3: `busy_o` stays high for exactly `WRITE_CYCLES` consecutive cycles per store.
- R4: A single-channel store ends with a one-cycle `done_o` pulse. In the cycle after `busy_o` falls, `nv_we_o` is one-hot with bit `req_pot_i` set, `nv_reg_o` equals the requested register index, and lane `req_pot_i` of `nv_data_o` holds the data captured with the request. Lane p is bits [p*DATA_W +: DATA_W].
- R5: A request with `req_global_i`=1 sets every bit of `nv_we_o` at the end of the store. Each lane of `nv_data_o` carries its own captured lane value, and all lanes target the same register index.
- R6: If `wp_ni` is low at the chip-select release, no store starts and the pending request is discarded. A later release with no new request starts nothing.
- R7: A selection window with no request strobe starts no store at its release.
- R8: A strobe that arrives while `busy_o` is 1 is ignored. The running store still completes with its own data, and no second store follows.
- R9: If several strobes arrive in one selection window, the last one is the one committed.
- R10: A strobe while `cs_ni` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wp_ni | input | 1 | Write protect, active low |
| req_valid_i | input | 1 | Strobe: a complete store command was received |
| req_global_i | input | 1 | 1 = store to all channels, 0 = one channel |
| req_pot_i | input | POT_W | Channel index for a single-channel store |
| req_reg_i | input | REG_W | Target data-register index |
| req_data_i | input | NUM_POTS*DATA_W | Per-channel data lanes to store |
| busy_o | output | 1 | Store in progress (write-in-progress bit) |
| done_o | output | 1 | One-cycle pulse at store end |
| nv_we_o | output | NUM_POTS | Per-channel storage write enables |
| nv_reg_o | output | REG_W | Register index written |
| nv_data_o | output | NUM_POTS*DATA_W | Data lanes written |

## Verification
The release edge is seen at the first clock edge that samples `cs_ni` high, so `busy_o` is checked at the next falling clock edge. The check then counts `WRITE_CYCLES` busy samples and expects `done_o` with the write enables exactly one sample after the last one. The bench drives every input on the falling edge and samples only on the falling edge, and it scans a window longer than the delay. Because of that, a store that starts a cycle early or late, or runs too long or too short, changes a counted value and is reported. Rejected requests are checked by following them with a clean release and confirming that no busy sample and no done pulse appears.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [0:0] {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/nvc_cs_edge.sv
module nvc_cs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic rise_o
);
  logic cs_q;

  // reset to deselected so the first low-to-high needs a real selection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end

  assign rise_o = cs_ni & ~cs_q;
endmodule

// File: rtl/nvc_pending.sv
module nvc_pending #(
  parameter int unsigned NUM_POTS = 4,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 6,
  localparam int unsigned POT_W   = nvc_pkg::clog2_min1(NUM_POTS),
  localparam int unsigned REG_W   = nvc_pkg::clog2_min1(NUM_REGS),
  localparam int unsigned BUS_W   = NUM_POTS * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                clear_i,
  input  logic                global_i,
  input  logic [POT_W-1:0]    pot_i,
  input  logic [REG_W-1:0]    reg_i,
  input  logic [BUS_W-1:0]    data_i,
  output logic                valid_o,
  output logic [NUM_POTS-1:0] lanes_o,
  output logic [REG_W-1:0]    reg_o,
  output logic [BUS_W-1:0]    data_o
);
  logic [NUM_POTS-1:0] lane_sel;

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_lane
    assign lane_sel[p] = global_i | (pot_i == POT_W'(p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      lanes_o <= '0;
      reg_o   <= '0;
      data_o  <= '0;
    end else if (capture_i) begin
      // a later strobe in the same window overwrites the earlier one
      valid_o <= 1'b1;
      lanes_o <= lane_sel;
      reg_o   <= reg_i;
      data_o  <= data_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nvc_busy_timer.sv
module nvc_busy_timer #(
  parameter int unsigned WRITE_CYCLES = 500000,
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  import nvc_pkg::*;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        TMR_IDLE: if (start_i) begin
          state_q <= TMR_RUN;
          cnt_q   <= CNT_W'(WRITE_CYCLES - 1);
        end
        TMR_RUN: begin
          if (cnt_q == '0) begin
            state_q <= TMR_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= TMR_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == TMR_RUN);
endmodule

// File: rtl/nvc_commit_seq.sv
module nvc_commit_seq #(
  parameter int unsigned NUM_POTS     = 4,
  parameter int unsigned NUM_REGS     = 4,
  parameter int unsigned DATA_W       = 6,
  parameter int unsigned WRITE_CYCLES = 500000,
  localparam int unsigned POT_W       = nvc_pkg::clog2_min1(NUM_POTS),
  localparam int unsigned REG_W       = nvc_pkg::clog2_min1(NUM_REGS),
  localparam int unsigned BUS_W       = NUM_POTS * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                wp_ni,
  input  logic                req_valid_i,
  input  logic                req_global_i,
  input  logic [POT_W-1:0]    req_pot_i,
  input  logic [REG_W-1:0]    req_reg_i,
  input  logic [BUS_W-1:0]    req_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [NUM_POTS-1:0] nv_we_o,
  output logic [REG_W-1:0]    nv_reg_o,
  output logic [BUS_W-1:0]    nv_data_o
);
  logic                cs_rise;
  logic                capture;
  logic                start;
  logic                pend_valid;
  logic [NUM_POTS-1:0] pend_lanes;

  nvc_cs_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .rise_o (cs_rise)
  );

  // strobes count only while selected and idle
  assign capture = req_valid_i & ~cs_ni & ~busy_o;

  nvc_pending #(
    .NUM_POTS (NUM_POTS),
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .clear_i   (cs_rise),
    .global_i  (req_global_i),
    .pot_i     (req_pot_i),
    .reg_i     (req_reg_i),
    .data_i    (req_data_i),
    .valid_o   (pend_valid),
    .lanes_o   (pend_lanes),
    .reg_o     (nv_reg_o),
    .data_o    (nv_data_o)
  );

  assign start = cs_rise & pend_valid & wp_ni & ~busy_o;

  nvc_busy_timer #(
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign nv_we_o = done_o ? pend_lanes : '0;
endmodule

// File: rtl/nvc_commit_seq_chk.sv
module nvc_commit_seq_chk #(
  parameter int unsigned NUM_POTS     = 4,
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                wp_ni,
  input logic                busy_o,
  input logic                done_o,
  input logic [NUM_POTS-1:0] nv_we_o
);
  int unsigned bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= 0;
    else if (busy_o) bcnt <= bcnt + 1;
    else             bcnt <= 0;
  end

  assert_start_on_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_ni));

  assert_protect_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wp_ni));

  assert_busy_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (bcnt == WRITE_CYCLES));

  assert_busy_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt <= WRITE_CYCLES);

  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_we_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nv_we_o != '0));

  assert_we_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (nv_we_o == '0));
endmodule

bind nvc_commit_seq nvc_commit_seq_chk #(
  .NUM_POTS     (NUM_POTS),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .wp_ni   (wp_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .nv_we_o (nv_we_o)
);

// File: tb/nvc_commit_seq_test.sv
module nvc_commit_seq_test;
  localparam int NP = 4;
  localparam int NR = 4;
  localparam int DW = 6;
  localparam int WC = 8;
  localparam int PW = 2;
  localparam int RW = 2;
  localparam int BW = NP * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic wp_n = 1'b1;
  logic rq_v = 1'b0;
  logic rq_g = 1'b0;
  logic [PW-1:0] rq_p = '0;
  logic [RW-1:0] rq_r = '0;
  logic [BW-1:0] rq_d = '0;
  logic busy, done;
  logic [NP-1:0] we;
  logic [RW-1:0] nreg;
  logic [BW-1:0] ndata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nvc_commit_seq #(
    .NUM_POTS(NP), .NUM_REGS(NR), .DATA_W(DW), .WRITE_CYCLES(WC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wp_ni(wp_n),
    .req_valid_i(rq_v), .req_global_i(rq_g), .req_pot_i(rq_p),
    .req_reg_i(rq_r), .req_data_i(rq_d),
    .busy_o(busy), .done_o(done), .nv_we_o(we), .nv_reg_o(nreg), .nv_data_o(ndata)
  );

  function automatic logic [BW-1:0] pattern(input int seed);
    logic [BW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*DW +: DW] = DW'((p * 13 + seed * 11 + 3) % 64);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input bit strobe, input bit g, input int p, input int r,
                       input logic [BW-1:0] d, input bit wp);
    @(negedge clk); cs_n = 1'b0; wp_n = wp;
    @(negedge clk);
    rq_v = strobe; rq_g = g; rq_p = PW'(p); rq_r = RW'(r); rq_d = d;
    @(negedge clk); rq_v = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  // watch the window after a release; exp_we==0 means no store expected
  task automatic observe(input string req, input logic [NP-1:0] exp_we, input int r,
                         input logic [BW-1:0] d);
    int bc = 0, dc = 0, first = 0, dpos = 0;
    logic [NP-1:0] swe = '0;
    logic [RW-1:0] sreg = '0;
    logic [BW-1:0] sdat = '0;
    for (int i = 1; i <= WC + 4; i++) begin
      @(negedge clk);
      if (busy) begin bc++; if (bc == 1) first = i; end
      if (done) begin dc++; dpos = i; swe = we; sreg = nreg; sdat = ndata; end
    end
    wp_n = 1'b1;
    if (exp_we == '0) begin
      check(bc == 0, req, bc, 0);
      check(dc == 0, req, dc, 0);
    end else begin
      check(first == 1, {req, " start R2"}, first, 1);
      check(bc == WC, {req, " length R3"}, bc, WC);
      check(dc == 1 && dpos == WC + 1, {req, " done R4"}, dpos, WC + 1);
      check(swe == exp_we, {req, " we"}, swe, exp_we);
      check(sreg == RW'(r), {req, " reg"}, sreg, r);
      for (int p = 0; p < NP; p++)
        if (exp_we[p])
          check(sdat[p*DW +: DW] == d[p*DW +: DW], {req, " lane"},
                sdat[p*DW +: DW], d[p*DW +: DW]);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(we == '0, "R1 we", we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 single-channel sweep over every channel and register
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) begin
        frame(1'b1, 1'b0, p, r, pattern(p * NR + r), 1'b1);
        observe("R4 single", NP'(1) << p, r, pattern(p * NR + r));
      end

    // R5 global store per register
    for (int r = 0; r < NR; r++) begin
      frame(1'b1, 1'b1, 0, r, pattern(40 + r), 1'b1);
      observe("R5 global", '1, r, pattern(40 + r));
    end

    // R7 window without strobe
    frame(1'b0, 1'b0, 1, 1, pattern(1), 1'b1);
    observe("R7 no strobe", '0, 0, '0);

    // R6 protect low discards, then a clean release starts nothing
    frame(1'b1, 1'b0, 2, 3, pattern(7), 1'b0);
    observe("R6 protected", '0, 0, '0);
    frame(1'b0, 1'b0, 0, 0, '0, 1'b1);
    observe("R6 discarded", '0, 0, '0);

    // R10 strobe while deselected
    @(negedge clk); rq_v = 1'b1; rq_p = 2'd3; rq_r = 2'd2; rq_d = pattern(9);
    @(negedge clk); rq_v = 1'b0;
    frame(1'b0, 1'b0, 0, 0, '0, 1'b1);
    observe("R10 deselected strobe", '0, 0, '0);

    // R9 last strobe in the window wins
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); rq_v = 1'b1; rq_g = 1'b0; rq_p = 2'd0; rq_r = 2'd1; rq_d = pattern(20);
    @(negedge clk); rq_p = 2'd2; rq_r = 2'd3; rq_d = pattern(21);
    @(negedge clk); rq_v = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    observe("R9 last wins", 4'b0100, 3, pattern(21));

    // R8 strobe during busy is dropped; first store completes untouched
    begin
      int dc = 0;
      logic [RW-1:0] sreg = '0;
      logic [BW-1:0] sdat = '0;
      logic [NP-1:0] swe = '0;
      frame(1'b1, 1'b0, 1, 2, pattern(30), 1'b1);
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk); rq_v = 1'b1; rq_p = 2'd3; rq_r = 2'd0; rq_d = pattern(31);
      @(negedge clk); rq_v = 1'b0;
      @(negedge clk); cs_n = 1'b1;
      for (int i = 0; i < 3 * WC; i++) begin
        @(negedge clk);
        if (done) begin dc++; swe = we; sreg = nreg; sdat = ndata; end
      end
      check(dc == 1, "R8 single done", dc, 1);
      check(swe == 4'b0010, "R8 we kept", swe, 2);
      check(sreg == 2'd2, "R8 reg kept", sreg, 2);
      check(sdat[DW +: DW] == pattern(30)[DW +: DW], "R8 data kept",
            sdat[DW +: DW], pattern(30)[DW +: DW]);
      frame(1'b0, 1'b0, 0, 0, '0, 1'b1);
      observe("R8 no follow-up", '0, 0, '0);
    end

    // R2 strobe alone (no release yet) keeps busy low
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); rq_v = 1'b1; rq_p = 2'd1; rq_r = 2'd1; rq_d = pattern(50);
    @(negedge clk); rq_v = 1'b0;
    repeat (WC + 2) @(negedge clk);
    check(busy == 1'b0, "R2 no release", busy, 0);
    cs_n = 1'b1;
    observe("R2 on release", 4'b0010, 1, pattern(50));

    finish_run();
  end
endmodule